// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for a single access of one kind: a data read, a data write, an instruction fetch, or a probe that needs no particular right. A request is taken in one cycle. Three kinds of request finish without any memory traffic: physical-mode requests, addresses that are not properly sign-extended, and addresses inside the kernel superpage window. All other addresses go through a three-level table walk. Each level costs one 8-byte read on a simple request/response port.

At each level the walker checks the entry's valid bit. At the two upper levels it also checks the kernel read-enable bit. At the leaf it builds the read/execute and write rights from enable bits selected by the privilege mode, then clears rights whose fault-on bit is set. The result is reported with a one-cycle done pulse. It is either a physical address with protection bits or a fault code. Pages are 8 KiB and the implemented virtual width is 43 bits.

Encodings used throughout:
- Access: 0 read, 1 write, 2 fetch, 3 probe.
- Mode: 0 kernel, 1 executive, 2 supervisor, 3 user.
- Protection: bit 0 read, bit 1 write, bit 2 execute.
- Fault code: 0 none, 1 access violation, 2 translation not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute.

Top module: `ptw_walker`

## Requirements
- R1: With `req_phys` high, the result is the request address unchanged, protection 3'b111 and fault code 0, with no table read; the sign and superpage rules do not apply.
- R2: If bits 63 down to 43 of the address are not all equal, the result is fault code 1 (access violation) with no table read.
- R3: If bits 63..43 are all ones and bits 42:41 equal 2'b10, the address is a superpage. In kernel mode the physical address is address bits 39:0, with address bit 40 placed at physical bit 43 and all other bits zero. Protection is 3'b111, code 0, and there is no table read.
- R4: A superpage address used in any mode other than kernel gives fault code 1 with no table read; a negative address whose bits 42:41 are not 2'b10 is walked as normal.
- R5: A walk reads at most three entries, at address base + index*8, using index bits 42:33, then 32:23, then 22:13. The first base is `table_root`. Each later base is entry bits 63:32 shifted left by 13.
- R6: An entry read at any level with bit 0 (valid) clear ends the walk with fault code 2.
- R7: At the first two levels, a valid entry with bit 8 (kernel read enable) clear ends the walk with fault code 1.
- R8: At the leaf, read and execute rights come from entry bit 8+mode and the write right from bit 12+mode. If none of the needed right is granted, the result is fault code 1.
- R9: At the leaf, entry bit 1 removes read, bit 2 removes write and bit 3 removes execute. A needed right that is lost this way gives fault-on-execute (5) first, then fault-on-write (4), then fault-on-read (3).
- R10: A successful walk returns entry bits 63:32 shifted left by 13, ORed with address bits 12:0, together with the rights left after R9, and fault code 0.
- R11: A probe (access 3) needs no right. It never gives codes 1, 3, 4 or 5 at the leaf, and returns the masked rights.
- R12: After reset the block is idle: `busy_o`, `done_o` and `mem_rd_valid` are low. A request is taken only while `busy_o` is low, and one raised while busy is dropped. At most one table read is outstanding. `done_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request, taken when `busy_o` is low |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 probe) |
| req_mode | input | 2 | Privilege mode index (0 kernel .. 3 user) |
| req_phys | input | 1 | Physical-mode bypass |
| table_root | input | 64 | Base address of the top-level table |
| busy_o | output | 1 | Request in progress |
| mem_rd_valid | output | 1 | Table read request, one cycle per read |
| mem_rd_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Table entry |
| done_o | output | 1 | Result valid for one cycle |
| res_paddr | output | 64 | Physical address |
| res_prot | output | 3 | Granted rights (bit 0 read, 1 write, 2 execute) |
| res_code | output | 3 | Fault code, 0 on success |

## Verification
The translation is tried with four groups of addresses:
- Physical-mode addresses that are deliberately non-canonical. These show that the bypass takes precedence over the sign check.
- Non-canonical and superpage addresses in several modes. These separate the window test from the kernel-only rule and confirm the bit-40 relocation.
- A negative address outside the window. This shows that it falls through to a walk.
- A hand-built table whose entries differ in valid, kernel-read, per-mode enable and fault-on bits. Walking it in each access kind separates faults at each level and access violations from each fault-on code. The number of table reads tells at which level a walk stopped.

Variable response delays and a request raised in the middle of a walk show that results do not depend on memory timing and that busy-time requests are dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      FC_NONE = 3'd0,
      FC_ACV  = 3'd1,
      FC_TNV  = 3'd2,
      FC_FOR  = 3'd3,
      FC_FOW  = 3'd4,
      FC_FOE  = 3'd5
   } fault_e;

   typedef enum logic [1:0] {
      ACC_RD    = 2'd0,
      ACC_WR    = 2'd1,
      ACC_EX    = 2'd2,
      ACC_PROBE = 2'd3
   } access_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } walk_st_e;

   typedef enum logic [1:0] {
      RT_BYPASS,
      RT_FAULT,
      RT_SUPER,
      RT_WALK
   } route_e;

   localparam logic [2:0] PROT_ALL = 3'b111;
   localparam int PR_R = 0;
   localparam int PR_W = 1;
   localparam int PR_X = 2;

   function automatic logic [2:0] need_of(input logic [1:0] acc);
      logic [2:0] n;
      case (acc)
         ACC_RD:  n = 3'b001;
         ACC_WR:  n = 3'b010;
         ACC_EX:  n = 3'b100;
         default: n = 3'b000;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
   import ptw_pkg::*;
#(
   parameter int VA_BITS     = 43,
   parameter int SP_LOW_BITS = 40,
   parameter int SP_MOVE_TO  = 43
) (
   input  logic [63:0] vaddr,
   input  logic        phys,
   input  logic [1:0]  mode,
   output route_e      route,
   output logic [63:0] paddr,
   output fault_e      code
);
   localparam int HI_W = 64 - VA_BITS;

   logic [HI_W-1:0] hi_bits;
   logic            canonical;
   logic            in_window;
   logic [63:0]     sp_addr;

   assign hi_bits   = vaddr[63:VA_BITS];
   assign canonical = (&hi_bits) | ~(|hi_bits);
   assign in_window = vaddr[63] && (vaddr[VA_BITS-1 -: 2] == 2'b10);

   always_comb begin
      sp_addr = '0;
      sp_addr[SP_LOW_BITS-1:0] = vaddr[SP_LOW_BITS-1:0];
      sp_addr[SP_MOVE_TO]      = vaddr[SP_LOW_BITS];
   end

   always_comb begin
      route = RT_WALK;
      paddr = '0;
      code  = FC_NONE;
      if (phys) begin
         route = RT_BYPASS;
         paddr = vaddr;
      end else if (!canonical) begin
         route = RT_FAULT;
         code  = FC_ACV;
      end else if (in_window) begin
         if (mode == 2'd0) begin
            route = RT_SUPER;
            paddr = sp_addr;
         end else begin
            route = RT_FAULT;
            code  = FC_ACV;
         end
      end
   end

endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
   parameter int LEVELS   = 3,
   parameter int IDX_BITS = 10,
   parameter int LVL_W    = 2,
   localparam int SPAN    = LEVELS * IDX_BITS
) (
   input  logic [SPAN-1:0]     vpn,
   input  logic [LVL_W-1:0]    lvl,
   output logic [IDX_BITS-1:0] idx
);
   logic [IDX_BITS-1:0] slice [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign slice[g] = vpn[(LEVELS-1-g)*IDX_BITS +: IDX_BITS];
   end

   always_comb begin
      idx = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) idx = slice[l];
      end
   end

endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
   import ptw_pkg::*;
#(
   parameter int PTE_W  = 64,
   parameter int RE_LSB = 8,
   parameter int WE_LSB = 12
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       mode,
   input  logic [2:0]       need,
   output logic [2:0]       prot,
   output fault_e           code
);
   logic       re;
   logic       we;
   logic [2:0] granted;
   logic [2:0] lost;

   assign re      = pte[RE_LSB + int'(mode)];
   assign we      = pte[WE_LSB + int'(mode)];
   assign granted = {re, we, re};
   assign lost    = pte[3:1];
   assign prot    = granted & ~lost;

   always_comb begin
      code = FC_NONE;
      if (need != 3'b000 && (granted & need) == 3'b000) begin
         code = FC_ACV;
      end else if (need != 3'b000 && (prot & need) == 3'b000) begin
         if (need[PR_X])      code = FC_FOE;
         else if (need[PR_W]) code = FC_FOW;
         else                 code = FC_FOR;
      end
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_BITS     = 43,
   parameter int PAGE_BITS   = 13,
   parameter int IDX_BITS    = 10,
   parameter int LEVELS      = 3,
   parameter int PTE_W       = 64,
   parameter int FRAME_LSB   = 32,
   parameter int VALID_BIT   = 0,
   parameter int RE_LSB      = 8,
   parameter int WE_LSB      = 12,
   parameter int SP_LOW_BITS = 40,
   parameter int SP_MOVE_TO  = 43
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [63:0] req_vaddr,
   input  logic [1:0]  req_access,
   input  logic [1:0]  req_mode,
   input  logic        req_phys,
   input  logic [63:0] table_root,
   output logic        busy_o,
   output logic        mem_rd_valid,
   output logic [63:0] mem_rd_addr,
   input  logic        mem_rsp_valid,
   input  logic [63:0] mem_rsp_data,
   output logic        done_o,
   output logic [63:0] res_paddr,
   output logic [2:0]  res_prot,
   output logic [2:0]  res_code
);
   localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
   localparam int SPAN        = LEVELS * IDX_BITS;
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   if (SPAN + PAGE_BITS != VA_BITS) begin : g_bad_span
      $error("index fields plus page offset must equal VA_BITS");
   end
   if (VA_BITS >= 64 || VA_BITS < 3) begin : g_bad_va
      $error("VA_BITS out of range");
   end
   if (WE_LSB + 3 >= FRAME_LSB || RE_LSB + 3 >= WE_LSB) begin : g_bad_pte
      $error("enable fields overlap");
   end
   if (SP_MOVE_TO > 63 || SP_LOW_BITS >= VA_BITS - 2) begin : g_bad_sp
      $error("superpage bit positions out of range");
   end

   walk_st_e            st_q;
   logic [63:0]         va_q;
   logic [1:0]          mode_q;
   logic [2:0]          need_q;
   logic [63:0]         base_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [63:0]         paddr_q;
   logic [2:0]          prot_q;
   fault_e              code_q;

   route_e              cl_route;
   logic [63:0]         cl_paddr;
   fault_e              cl_code;
   logic [IDX_BITS-1:0] cur_idx;
   logic [63:0]         next_base;
   logic [2:0]          leaf_prot;
   fault_e              leaf_code;
   logic                unused_bits;

   ptw_classify #(
      .VA_BITS     (VA_BITS),
      .SP_LOW_BITS (SP_LOW_BITS),
      .SP_MOVE_TO  (SP_MOVE_TO)
   ) u_cls (
      .vaddr (req_vaddr),
      .phys  (req_phys),
      .mode  (req_mode),
      .route (cl_route),
      .paddr (cl_paddr),
      .code  (cl_code)
   );

   ptw_index #(
      .LEVELS   (LEVELS),
      .IDX_BITS (IDX_BITS),
      .LVL_W    (LVL_W)
   ) u_idx (
      .vpn (va_q[VA_BITS-1:PAGE_BITS]),
      .lvl (lvl_q),
      .idx (cur_idx)
   );

   ptw_leaf #(
      .PTE_W  (PTE_W),
      .RE_LSB (RE_LSB),
      .WE_LSB (WE_LSB)
   ) u_leaf (
      .pte  (mem_rsp_data[PTE_W-1:0]),
      .mode (mode_q),
      .need (need_q),
      .prot (leaf_prot),
      .code (leaf_code)
   );

   assign next_base   = 64'(mem_rsp_data[PTE_W-1:FRAME_LSB]) << PAGE_BITS;
   assign unused_bits = ^{va_q[63:VA_BITS], mem_rsp_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         mode_q  <= '0;
         need_q  <= '0;
         base_q  <= '0;
         lvl_q   <= '0;
         paddr_q <= '0;
         prot_q  <= '0;
         code_q  <= FC_NONE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  mode_q <= req_mode;
                  need_q <= need_of(req_access);
                  case (cl_route)
                     RT_WALK: begin
                        base_q <= table_root;
                        lvl_q  <= '0;
                        st_q   <= ST_ISSUE;
                     end
                     RT_FAULT: begin
                        paddr_q <= '0;
                        prot_q  <= '0;
                        code_q  <= cl_code;
                        st_q    <= ST_DONE;
                     end
                     default: begin
                        paddr_q <= cl_paddr;
                        prot_q  <= PROT_ALL;
                        code_q  <= FC_NONE;
                        st_q    <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!mem_rsp_data[VALID_BIT]) begin
                     paddr_q <= '0;
                     prot_q  <= '0;
                     code_q  <= FC_TNV;
                     st_q    <= ST_DONE;
                  end else if (lvl_q != LAST_LVL) begin
                     if (!mem_rsp_data[RE_LSB]) begin
                        paddr_q <= '0;
                        prot_q  <= '0;
                        code_q  <= FC_ACV;
                        st_q    <= ST_DONE;
                     end else begin
                        base_q <= next_base;
                        lvl_q  <= lvl_q + 1'b1;
                        st_q   <= ST_ISSUE;
                     end
                  end else begin
                     paddr_q <= next_base | 64'(va_q[PAGE_BITS-1:0]);
                     prot_q  <= leaf_prot;
                     code_q  <= leaf_code;
                     st_q    <= ST_DONE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o       = (st_q != ST_IDLE);
   assign done_o       = (st_q == ST_DONE);
   assign mem_rd_valid = (st_q == ST_ISSUE);
   assign mem_rd_addr  = base_q + (64'(cur_idx) << ENTRY_SHIFT);
   assign res_paddr    = paddr_q;
   assign res_prot     = prot_q;
   assign res_code     = code_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [63:0] req_vaddr,
   input logic [1:0]  req_access,
   input logic [1:0]  req_mode,
   input logic        req_phys,
   input logic        busy_o,
   input logic        mem_rd_valid,
   input logic        done_o,
   input logic [63:0] res_paddr,
   input logic [2:0]  res_prot,
   input logic [2:0]  res_code
);
   logic [63:0] cap_va;
   logic        cap_phys;
   logic [1:0]  cap_mode;
   logic [1:0]  cap_acc;
   logic        cap_sp;
   logic [2:0]  cap_need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_va   <= '0;
         cap_phys <= 1'b0;
         cap_mode <= '0;
         cap_acc  <= '0;
      end else if (req_valid && !busy_o) begin
         cap_va   <= req_vaddr;
         cap_phys <= req_phys;
         cap_mode <= req_mode;
         cap_acc  <= req_access;
      end
   end

   assign cap_sp   = (&cap_va[63:43]) && (cap_va[42:41] == 2'b10);
   assign cap_need = (cap_acc == 2'd3) ? 3'b000 : (3'b001 << cap_acc);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R12
   read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> busy_o);

   // R1
   phys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_phys) |->
         (res_paddr == cap_va && res_prot == 3'b111 && res_code == 3'd0));

   // R3
   superpage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cap_phys && cap_sp && cap_mode == 2'd0) |->
         (res_paddr[39:0] == cap_va[39:0] && res_paddr[43] == cap_va[40] &&
          res_paddr[42:40] == 3'b000 && res_paddr[63:44] == '0 &&
          res_prot == 3'b111 && res_code == 3'd0));

   // R4
   superpage_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cap_phys && cap_sp && cap_mode != 2'd0) |-> res_code == 3'd1);

   // R10
   granted_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && res_code == 3'd0 && cap_need != 3'b000) |->
         (res_prot & cap_need) != 3'b000);

   // R11
   probe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cap_phys && !cap_sp && cap_acc == 2'd3 &&
       (&cap_va[63:43] || ~|cap_va[63:43])) |->
         (res_code == 3'd0 || res_code == 3'd2 || $past(mem_rd_valid, 2)
          || res_code == 3'd1));

endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_access = '0;
   logic [1:0]  req_mode = '0;
   logic        req_phys = 1'b0;
   logic [63:0] table_root = 64'h0010_0000;
   logic        busy_o;
   logic        mem_rd_valid;
   logic [63:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done_o;
   logic [63:0] res_paddr;
   logic [2:0]  res_prot;
   logic [2:0]  res_code;

   int n_checks = 0;
   int n_fail = 0;
   logic [63:0] mem [logic [63:0]];

   always #2 clk = ~clk;

   ptw_walker uut (.*);

   typedef struct packed {
      logic [63:0] va;
      logic [1:0]  acc;
      logic [1:0]  mode;
      logic        phys;
      logic [2:0]  code;
      logic [63:0] pa;
      logic [2:0]  prot;
      logic [1:0]  reads;
      logic [3:0]  rq;
   } vec_t;

   function automatic logic [63:0] va_of(int l1, int l2, int l3, int off);
      return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(off);
   endfunction

   localparam int NV = 25;
   // access 0 rd 1 wr 2 ex 3 probe; mode 0 kernel 3 user; code 1 ACV 2 TNV 3 FOR 4 FOW 5 FOE
   localparam vec_t VECS [NV] = '{
      '{64'hFFFF_0000_1234_5678, 2'd0, 2'd3, 1'b1, 3'd0, 64'hFFFF_0000_1234_5678, 3'd7, 2'd0, 4'd1},  // R1
      '{64'h0123_4567_89AB_CDEF, 2'd1, 2'd0, 1'b1, 3'd0, 64'h0123_4567_89AB_CDEF, 3'd7, 2'd0, 4'd1},  // R1
      '{64'h0000_0800_0000_0000, 2'd0, 2'd0, 1'b0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd2},                    // R2
      '{64'h8000_0000_0000_0000, 2'd2, 2'd0, 1'b0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd2},                    // R2
      '{64'hFFFF_FD12_3456_7890, 2'd0, 2'd0, 1'b0, 3'd0, 64'h0000_0812_3456_7890, 3'd7, 2'd0, 4'd3},  // R3
      '{64'hFFFF_FC00_0000_0ABC, 2'd2, 2'd0, 1'b0, 3'd0, 64'h0000_0000_0000_0ABC, 3'd7, 2'd0, 4'd3},  // R3
      '{64'hFFFF_FD12_3456_7890, 2'd0, 2'd3, 1'b0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd4},                    // R4
      '{64'hFFFF_FD12_3456_7890, 2'd1, 2'd1, 1'b0, 3'd1, 64'h0, 3'd0, 2'd0, 4'd4},                    // R4
      '{64'hFFFF_F800_0000_0000, 2'd0, 2'd0, 1'b0, 3'd2, 64'h0, 3'd0, 2'd1, 4'd4},                    // R4
      '{va_of(1,2,0,'h1AB), 2'd0, 2'd0, 1'b0, 3'd0, 64'h0A00_01AB, 3'd7, 2'd3, 4'd10},               // R10
      '{va_of(1,2,0,'h1FFF), 2'd1, 2'd0, 1'b0, 3'd0, 64'h0A00_1FFF, 3'd7, 2'd3, 4'd5},               // R5
      '{va_of(1,2,1,'h10), 2'd0, 2'd3, 1'b0, 3'd0, 64'h0C00_0010, 3'd5, 2'd3, 4'd8},                 // R8
      '{va_of(1,2,1,0), 2'd1, 2'd3, 1'b0, 3'd1, 64'h0, 3'd0, 2'd3, 4'd8},                            // R8
      '{va_of(1,2,1,0), 2'd0, 2'd0, 1'b0, 3'd1, 64'h0, 3'd0, 2'd3, 4'd8},                            // R8
      '{va_of(1,2,2,'h40), 2'd1, 2'd0, 1'b0, 3'd4, 64'h0, 3'd0, 2'd3, 4'd9},                         // R9
      '{va_of(1,2,2,'h40), 2'd0, 2'd0, 1'b0, 3'd0, 64'h0E00_0040, 3'd5, 2'd3, 4'd9},                 // R9
      '{va_of(1,2,3,0), 2'd0, 2'd0, 1'b0, 3'd3, 64'h0, 3'd0, 2'd3, 4'd9},                            // R9
      '{va_of(1,2,3,0), 2'd2, 2'd0, 1'b0, 3'd5, 64'h0, 3'd0, 2'd3, 4'd9},                            // R9
      '{va_of(1,2,3,8), 2'd3, 2'd0, 1'b0, 3'd0, 64'h1000_0008, 3'd0, 2'd3, 4'd11},                   // R11
      '{va_of(1,2,4,0), 2'd0, 2'd0, 1'b0, 3'd2, 64'h0, 3'd0, 2'd3, 4'd6},                            // R6
      '{va_of(3,0,0,0), 2'd0, 2'd0, 1'b0, 3'd1, 64'h0, 3'd0, 2'd1, 4'd7},                            // R7
      '{va_of(5,0,0,0), 2'd0, 2'd0, 1'b0, 3'd2, 64'h0, 3'd0, 2'd1, 4'd6},                            // R6
      '{va_of(1,7,0,0), 2'd1, 2'd0, 1'b0, 3'd2, 64'h0, 3'd0, 2'd2, 4'd6},                            // R6
      '{va_of(1,4,0,0), 2'd0, 2'd0, 1'b0, 3'd1, 64'h0, 3'd0, 2'd2, 4'd7},                            // R7
      '{va_of(1,2,1,0), 2'd3, 2'd3, 1'b0, 3'd0, 64'h0C00_0000, 3'd5, 2'd3, 4'd11}                    // R11
   };

   task automatic check(input bit ok, input int rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   task automatic run_one(input logic [63:0] va, input logic [1:0] acc,
                          input logic [1:0] mode, input logic phys,
                          input int delay, input bit intrude,
                          output logic [63:0] pa, output logic [2:0] prot,
                          output logic [2:0] code, output int reads,
                          output bit timed_out);
      int spins = 0;
      bit intruded = 0;
      reads = 0;
      timed_out = 0;
      @(negedge clk);
      req_vaddr  = va;
      req_access = acc;
      req_mode   = mode;
      req_phys   = phys;
      req_valid  = 1'b1;
      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         mem_rsp_valid = 1'b0;
         spins++;
         if (spins > 300) begin
            timed_out = 1;
            break;
         end
         if (done_o) begin
            pa = res_paddr;
            prot = res_prot;
            code = res_code;
            break;
         end
         if (mem_rd_valid) begin
            logic [63:0] a;
            a = mem_rd_addr;
            reads++;
            if (intrude && !intruded) begin
               intruded = 1;
               req_vaddr = 64'h0000_0000_DEAD_0000;
               req_phys  = 1'b1;
               req_valid = 1'b1;
            end
            repeat (1 + delay) begin
               @(negedge clk);
               req_valid = 1'b0;
            end
            mem_rsp_data  = rd(a);
            mem_rsp_valid = 1'b1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] pa;
      logic [2:0]  prot;
      logic [2:0]  code;
      int          reads;
      bit          to;

      mem[64'h0010_0008] = {32'h0000_0100, 32'h0000_0101};
      mem[64'h0010_0018] = {32'h0000_0000, 32'h0000_0001};
      mem[64'h0020_0010] = {32'h0000_0101, 32'h0000_0101};
      mem[64'h0020_0020] = {32'h0000_0000, 32'h0000_0001};
      mem[64'h0020_2000] = {32'h0000_5000, 32'h0000_1101};
      mem[64'h0020_2008] = {32'h0000_6000, 32'h0000_0801};
      mem[64'h0020_2010] = {32'h0000_7000, 32'h0000_1105};
      mem[64'h0020_2018] = {32'h0000_8000, 32'h0000_010B};

      repeat (3) @(negedge clk);
      // R12: idle after reset
      check(busy_o == 1'b0, 12, "busy after reset", 64'(busy_o), 0);
      check(done_o == 1'b0, 12, "done after reset", 64'(done_o), 0);
      check(mem_rd_valid == 1'b0, 12, "read after reset", 64'(mem_rd_valid), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run_one(VECS[i].va, VECS[i].acc, VECS[i].mode, VECS[i].phys, i % 3, 1'b0,
                 pa, prot, code, reads, to);
         check(!to, int'(VECS[i].rq), "timeout", 64'(to), 0);
         check(code == VECS[i].code, int'(VECS[i].rq), "fault code", 64'(code), 64'(VECS[i].code));
         check(reads == int'(VECS[i].reads), int'(VECS[i].rq), "table reads",
               64'(reads), 64'(VECS[i].reads));
         if (VECS[i].code == 3'd0) begin
            check(pa == VECS[i].pa, int'(VECS[i].rq), "paddr", pa, VECS[i].pa);
            check(prot == VECS[i].prot, int'(VECS[i].rq), "prot", 64'(prot), 64'(VECS[i].prot));
         end
      end

      // R12: request raised mid-walk is dropped
      run_one(va_of(1, 2, 0, 5), 2'd0, 2'd0, 1'b0, 2, 1'b1, pa, prot, code, reads, to);
      check(code == 3'd0, 12, "intrude code", 64'(code), 0);
      check(pa == 64'h0A00_0005, 12, "intrude paddr", pa, 64'h0A00_0005);
      check(reads == 3, 12, "intrude reads", 64'(reads), 3);
      @(negedge clk);
      check(busy_o == 1'b0 && done_o == 1'b0, 12, "no queued request",
            64'({busy_o, done_o}), 0);

      // R5: walk result independent of response delay
      run_one(va_of(1, 2, 2, 'h7), 2'd0, 2'd0, 1'b0, 5, 1'b0, pa, prot, code, reads, to);
      check(pa == 64'h0E00_0007 && prot == 3'd5, 5, "slow memory", pa, 64'h0E00_0007);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule